// File: doc/BRIEF.md
# Wide-Beat Read Bridge to a Half-Width Memory

This block is the read side of a memory-mapped slave. Its data bus is twice as wide as the synchronous memory behind it. A master asks for a burst on the address channel. For each wide beat of that burst, the bridge issues two back-to-back reads to the memory: first the lower word, then the word one narrow-word step above it. It joins the two words into one beat and presents that beat on the read-data channel.

The bridge serves one burst at a time. While a burst is in progress the address channel stays closed. The request identifier is latched at acceptance and repeated on every beat. Read-data backpressure is honoured: the memory is not touched while a finished beat waits for the master. Only incrementing bursts of full-width beats with aligned addresses are handled. With the default parameters the data bus is 128 bits wide and the memory is 64 bits wide. The memory returns data one cycle after the read strobe.

Top module: `wide_rd_bridge`

## Requirements
- R1: `arReady` is high only when no burst is in progress. It goes low in the cycle after an address handshake and returns high in the cycle after the handshake of the final data beat.
- R2: For a beat at byte address A, the bridge reads the memory at word address A/8 and then at A/8+1, in two consecutive cycles with `memRdEn` high.
- R3: `rData[63:0]` holds the word read from the lower memory address and `rData[127:64]` holds the word read from the higher address.
- R4: `rId` equals the `arId` sampled at the address handshake on every beat of the burst, even if `arId` changes afterwards.
- R5: A burst with length field L produces exactly L+1 beats and 2×(L+1) memory reads. The byte address of each beat is 16 above that of the previous beat, and the beat index wraps inside the memory.
- R6: `rValid` rises in the third cycle after the address handshake, and in the third cycle after each non-final data handshake. It is never high before both halves of the beat are captured.
- R7: While `rValid` is high and `rReady` is low, `rData`, `rId` and `rLast` hold their values.
- R8: `rLast` is high only on the final beat of a burst. `rResp` is always OKAY (2'b00).
- R9: During and right after reset, `arReady` is 1, `rValid` is 0 and `memRdEn` is 0. A reset in the middle of a burst abandons that burst.
- R10: `memRdEn` stays low while a beat is presented and while the bridge is idle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rstN | input | 1 | Synchronous reset, active low |
| arValid | input | 1 | Read address valid |
| arReady | output | 1 | Read address ready |
| arId | input | ID_W | Request identifier |
| arAddr | input | ADDR_W | Burst start byte address, aligned to the beat size |
| arLen | input | 8 | Number of beats minus one |
| rValid | output | 1 | Read data valid |
| rReady | input | 1 | Read data ready |
| rId | output | ID_W | Identifier returned with each beat |
| rData | output | 2*NARROW_W | Assembled wide beat |
| rResp | output | 2 | Response code, always OKAY |
| rLast | output | 1 | Final beat of the burst |
| memRdEn | output | 1 | Memory read strobe |
| memRdAddr | output | MEM_AW | Memory word address |
| memRdData | input | NARROW_W | Memory read word, valid one cycle after the strobe |

## Verification
Most faults in the sequencer show up on the very first beat. If a state is skipped, `rValid` rises earlier or later than three cycles after the handshake, or the two halves are swapped or duplicated in `rData`. A wrong beat counter or a wrong address step stays hidden until the second beat. It then shows as wrong data, an early or missing `rLast`, or a memory read count that disagrees with the length field. Stalls of several cycles on `rReady` expose any holding register that is overwritten while a beat waits. They also expose any read strobe that fires during such a stall.

// File: rtl/wide_rd_pkg.sv
package wide_rd_pkg;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_ISSUE_LO,
    ST_ISSUE_HI,
    ST_CATCH_HI,
    ST_SHOW
  } seq_state_e;

  // Strobes from the sequencer to the datapath
  typedef struct packed {
    logic       loadReq;   // latch id, start index and length
    logic       memEn;     // read strobe to memory
    logic       selHi;     // upper word of the current beat
    logic [1:0] grab;      // capture returning word into half [i]
    logic       advance;   // step to the next beat
  } strobe_t;

  localparam logic [1:0] RESP_OKAY = 2'b00;

endpackage

// File: rtl/wide_rd_ctrl.sv
module wide_rd_ctrl
  import wide_rd_pkg::*;
(
  input  logic    clk,
  input  logic    rstN,
  input  logic    arValid,
  input  logic    rReady,
  input  logic    lastBeat,
  output logic    arReady,
  output logic    rValid,
  output strobe_t stb
);

  seq_state_e st, stNext;

  always_ff @(posedge clk) begin
    if (!rstN) st <= ST_IDLE;
    else       st <= stNext;
  end

  always_comb begin
    stb    = '0;
    stNext = st;
    unique case (st)
      ST_IDLE: begin
        if (arValid) begin
          stb.loadReq = 1'b1;
          stNext      = ST_ISSUE_LO;
        end
      end
      ST_ISSUE_LO: begin
        stb.memEn = 1'b1;
        stNext    = ST_ISSUE_HI;
      end
      ST_ISSUE_HI: begin
        stb.memEn   = 1'b1;
        stb.selHi   = 1'b1;
        stb.grab[0] = 1'b1;
        stNext      = ST_CATCH_HI;
      end
      ST_CATCH_HI: begin
        stb.grab[1] = 1'b1;
        stNext      = ST_SHOW;
      end
      ST_SHOW: begin
        if (rReady) begin
          if (lastBeat) begin
            stNext = ST_IDLE;
          end else begin
            stb.advance = 1'b1;
            stNext      = ST_ISSUE_LO;
          end
        end
      end
      default: stNext = ST_IDLE;
    endcase
  end

  assign arReady = (st == ST_IDLE);
  assign rValid  = (st == ST_SHOW);

endmodule

// File: rtl/wide_rd_dpath.sv
module wide_rd_dpath
  import wide_rd_pkg::*;
#(
  parameter int ID_W     = 4,
  parameter int NARROW_W = 64,
  parameter int MEM_AW   = 10,
  parameter int ADDR_W   = 32
) (
  input  logic                  clk,
  input  logic                  rstN,
  input  strobe_t               stb,
  input  logic [ID_W-1:0]       arId,
  input  logic [ADDR_W-1:0]     arAddr,
  input  logic [7:0]            arLen,
  input  logic [NARROW_W-1:0]   memRdData,
  output logic [MEM_AW-1:0]     memRdAddr,
  output logic [ID_W-1:0]       rId,
  output logic [2*NARROW_W-1:0] rData,
  output logic                  lastBeat
);

  localparam int WORD_BYTES = NARROW_W / 8;
  localparam int WORD_SH    = $clog2(WORD_BYTES);
  localparam int BEAT_SH    = WORD_SH + 1;
  localparam int IDX_W      = MEM_AW - 1;

  logic [ID_W-1:0]     idReg;
  logic [IDX_W-1:0]    beatIdx;
  logic [7:0]          beatsLeft;
  logic [NARROW_W-1:0] half [2];

  // Address bits outside the beat index are not decoded
  logic unusedAddr;
  assign unusedAddr = ^arAddr;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      idReg     <= '0;
      beatIdx   <= '0;
      beatsLeft <= '0;
    end else if (stb.loadReq) begin
      idReg     <= arId;
      beatIdx   <= arAddr[BEAT_SH +: IDX_W];
      beatsLeft <= arLen;
    end else if (stb.advance) begin
      beatIdx   <= beatIdx + 1'b1;
      beatsLeft <= beatsLeft - 1'b1;
    end
  end

  // One holding register per half of the wide beat
  for (genvar h = 0; h < 2; h++) begin : g_half
    always_ff @(posedge clk) begin
      if (!rstN)           half[h] <= '0;
      else if (stb.grab[h]) half[h] <= memRdData;
    end
  end

  assign memRdAddr = {beatIdx, stb.selHi};
  assign rId       = idReg;
  assign rData     = {half[1], half[0]};
  assign lastBeat  = (beatsLeft == 8'd0);

endmodule

// File: rtl/wide_rd_bridge.sv
module wide_rd_bridge
  import wide_rd_pkg::*;
#(
  parameter int ID_W     = 4,
  parameter int NARROW_W = 64,
  parameter int MEM_AW   = 10,
  parameter int ADDR_W   = 32
) (
  input  logic                  clk,
  input  logic                  rstN,
  input  logic                  arValid,
  output logic                  arReady,
  input  logic [ID_W-1:0]       arId,
  input  logic [ADDR_W-1:0]     arAddr,
  input  logic [7:0]            arLen,
  output logic                  rValid,
  input  logic                  rReady,
  output logic [ID_W-1:0]       rId,
  output logic [2*NARROW_W-1:0] rData,
  output logic [1:0]            rResp,
  output logic                  rLast,
  output logic                  memRdEn,
  output logic [MEM_AW-1:0]     memRdAddr,
  input  logic [NARROW_W-1:0]   memRdData
);

  strobe_t stb;
  logic    lastBeat;

  wide_rd_ctrl u_ctrl (
    .clk      (clk),
    .rstN     (rstN),
    .arValid  (arValid),
    .rReady   (rReady),
    .lastBeat (lastBeat),
    .arReady  (arReady),
    .rValid   (rValid),
    .stb      (stb)
  );

  wide_rd_dpath #(
    .ID_W     (ID_W),
    .NARROW_W (NARROW_W),
    .MEM_AW   (MEM_AW),
    .ADDR_W   (ADDR_W)
  ) u_dpath (
    .clk       (clk),
    .rstN      (rstN),
    .stb       (stb),
    .arId      (arId),
    .arAddr    (arAddr),
    .arLen     (arLen),
    .memRdData (memRdData),
    .memRdAddr (memRdAddr),
    .rId       (rId),
    .rData     (rData),
    .lastBeat  (lastBeat)
  );

  assign memRdEn = stb.memEn;
  assign rLast   = rValid & lastBeat;
  assign rResp   = RESP_OKAY;

endmodule

// File: rtl/wide_rd_chk.sv
module wide_rd_chk #(
  parameter int ID_W     = 4,
  parameter int NARROW_W = 64,
  parameter int MEM_AW   = 10
) (
  input logic                  clk,
  input logic                  rstN,
  input logic                  arValid,
  input logic                  arReady,
  input logic [ID_W-1:0]       arId,
  input logic                  rValid,
  input logic                  rReady,
  input logic [ID_W-1:0]       rId,
  input logic [2*NARROW_W-1:0] rData,
  input logic [1:0]            rResp,
  input logic                  rLast,
  input logic                  memRdEn,
  input logic [MEM_AW-1:0]     memRdAddr
);

  logic [ID_W-1:0] seenId;
  always_ff @(posedge clk) begin
    if (!rstN)                   seenId <= '0;
    else if (arValid && arReady) seenId <= arId;
  end

  // R1
  no_accept_busy_chk: assert property (@(posedge clk) disable iff (!rstN)
    (rValid || memRdEn) |-> !arReady);

  // R2
  hi_follows_lo_chk: assert property (@(posedge clk) disable iff (!rstN)
    (memRdEn && !memRdAddr[0]) |=> (memRdEn && memRdAddr == $past(memRdAddr) + 1'b1));

  // R4
  id_match_chk: assert property (@(posedge clk) disable iff (!rstN)
    rValid |-> (rId == seenId));

  // R6
  valid_after_fill_chk: assert property (@(posedge clk) disable iff (!rstN)
    (rValid && !$past(rValid)) |-> (!$past(memRdEn) && $past(memRdEn, 2) && $past(memRdEn, 3)));

  // R7
  hold_on_stall_chk: assert property (@(posedge clk) disable iff (!rstN)
    (rValid && !rReady) |=> (rValid && $stable(rData) && $stable(rId) && $stable(rLast)));

  // R8
  resp_okay_chk: assert property (@(posedge clk) disable iff (!rstN)
    rValid |-> (rResp == 2'b00));

  // R8
  last_only_valid_chk: assert property (@(posedge clk) disable iff (!rstN)
    rLast |-> rValid);

  // R10
  mem_quiet_chk: assert property (@(posedge clk) disable iff (!rstN)
    (rValid || arReady) |-> !memRdEn);

endmodule

bind wide_rd_bridge wide_rd_chk #(
  .ID_W     (ID_W),
  .NARROW_W (NARROW_W),
  .MEM_AW   (MEM_AW)
) u_chk (
  .clk       (clk),
  .rstN      (rstN),
  .arValid   (arValid),
  .arReady   (arReady),
  .arId      (arId),
  .rValid    (rValid),
  .rReady    (rReady),
  .rId       (rId),
  .rData     (rData),
  .rResp     (rResp),
  .rLast     (rLast),
  .memRdEn   (memRdEn),
  .memRdAddr (memRdAddr)
);

// File: tb/wide_rd_bridge_test.sv
`timescale 1ns/1ps
module wide_rd_bridge_test;

  localparam int ID_W = 4;
  localparam int NW   = 64;
  localparam int MAW  = 10;
  localparam int AW   = 32;

  logic            clk = 1'b0;
  logic            rstN = 1'b0;
  logic            arValid = 1'b0;
  logic            arReady;
  logic [ID_W-1:0] arId = '0;
  logic [AW-1:0]   arAddr = '0;
  logic [7:0]      arLen = '0;
  logic            rValid;
  logic            rReady = 1'b0;
  logic [ID_W-1:0] rId;
  logic [2*NW-1:0] rData;
  logic [1:0]      rResp;
  logic            rLast;
  logic            memRdEn;
  logic [MAW-1:0]  memRdAddr;
  logic [NW-1:0]   memQ = '0;

  int nChecks = 0;
  int nFail   = 0;
  int rdCount = 0;
  bit done    = 1'b0;

  always #2 clk = ~clk;

  wide_rd_bridge #(.ID_W(ID_W), .NARROW_W(NW), .MEM_AW(MAW), .ADDR_W(AW)) uut (
    .clk(clk), .rstN(rstN), .arValid(arValid), .arReady(arReady), .arId(arId),
    .arAddr(arAddr), .arLen(arLen), .rValid(rValid), .rReady(rReady), .rId(rId),
    .rData(rData), .rResp(rResp), .rLast(rLast), .memRdEn(memRdEn),
    .memRdAddr(memRdAddr), .memRdData(memQ)
  );

  function automatic logic [NW-1:0] memWord(input logic [MAW-1:0] a);
    return {16'hA5C3, 6'd0, a, 22'h15A5A, a};
  endfunction

  // Registered-read memory model, one cycle latency
  always @(posedge clk) begin
    if (memRdEn) begin
      memQ    <= memWord(memRdAddr);
      rdCount <= rdCount + 1;
    end
  end

  task automatic chk(input bit ok, input string req, input logic [127:0] act, input logic [127:0] exp);
    nChecks++;
    if (!ok) begin
      nFail++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  // {id, byte address, length, stall cycles per beat}
  localparam logic [47:0] VECS [6] = '{
    {4'h3, 32'h0000_0000, 8'd0,  4'd0},
    {4'hA, 32'h0000_0120, 8'd3,  4'd0},
    {4'h5, 32'h0000_0340, 8'd2,  4'd3},
    {4'hF, 32'h0000_1FE0, 8'd2,  4'd1},
    {4'h0, 32'h0000_0800, 8'd15, 4'd0},
    {4'h9, 32'h0000_0050, 8'd4,  4'd5}
  };

  task automatic runBurst(input logic [ID_W-1:0] id, input logic [AW-1:0] addr,
                          input logic [7:0] len, input int stall);
    int startRd;
    logic [MAW-2:0] k;
    logic [2*NW-1:0] expData;
    @(negedge clk);
    arValid = 1'b1; arId = id; arAddr = addr; arLen = len;
    while (!arReady) @(negedge clk);
    startRd = rdCount;
    @(posedge clk);
    @(negedge clk);
    arValid = 1'b0; arId = ~id; arAddr = 32'hFFFF_FFF0; arLen = 8'hFF;
    for (int b = 0; b <= int'(len); b++) begin
      int lat = 0;
      while (!rValid && lat < 20) begin
        @(negedge clk);
        lat++;
      end
      chk(lat == 3, "R6 latency to rValid", 128'(lat), 128'd3);
      k = addr[MAW+2:4] + (MAW-1)'(b);
      expData = {memWord({k, 1'b1}), memWord({k, 1'b0})};
      chk(rData == expData, "R2/R3/R5 beat data", rData, expData);
      chk(rId == id, "R4 rId", 128'(rId), 128'(id));
      chk(rLast == (b == int'(len)), "R8 rLast", 128'(rLast), 128'(b == int'(len)));
      chk(rResp == 2'b00, "R8 rResp", 128'(rResp), 128'd0);
      chk(arReady == 1'b0, "R1 arReady busy", 128'(arReady), 128'd0);
      for (int s = 0; s < stall; s++) begin
        @(negedge clk);
        chk(rValid && rData == expData && rId == id && rLast == (b == int'(len)),
            "R7 hold during stall", rData, expData);
        chk(!memRdEn, "R10 no read while stalled", 128'(memRdEn), 128'd0);
      end
      rReady = 1'b1;
      @(posedge clk);
      @(negedge clk);
      rReady = 1'b0;
    end
    chk(rdCount - startRd == 2 * (int'(len) + 1), "R5 read count",
        128'(rdCount - startRd), 128'(2 * (int'(len) + 1)));
    chk(arReady == 1'b1 && !rValid, "R1 idle after last", 128'(arReady), 128'd1);
    chk(!memRdEn, "R10 no read when idle", 128'(memRdEn), 128'd0);
  endtask

  initial begin : watchdog
    repeat (100000) @(posedge clk);
    if (!done) begin
      nFail++;
      nChecks++;
      $display("FAIL watchdog expired");
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", nChecks, nFail);
      $finish;
    end
  end

  initial begin : main
    repeat (3) @(posedge clk);
    @(negedge clk);
    // R9 reset state
    chk(arReady && !rValid && !memRdEn, "R9 state in reset", {arReady, rValid, memRdEn}, 3'b100);
    rstN = 1'b1;
    @(negedge clk);
    chk(arReady && !rValid && !memRdEn, "R9 state after reset", {arReady, rValid, memRdEn}, 3'b100);

    for (int v = 0; v < 6; v++) begin
      runBurst(VECS[v][47:44], VECS[v][43:12], VECS[v][11:4], int'(VECS[v][3:0]));
    end

    // R1 address held valid during a burst is not taken again
    @(negedge clk);
    arValid = 1'b1; arId = 4'h6; arAddr = 32'h40; arLen = 8'd1;
    @(posedge clk);
    @(negedge clk);
    chk(!arReady, "R1 no second accept", 128'(arReady), 128'd0);
    repeat (3) @(negedge clk);
    chk(rValid && rId == 4'h6, "R4 id with arValid held", 128'(rId), 128'h6);
    arValid = 1'b0;
    repeat (2) begin
      while (!rValid) @(negedge clk);
      rReady = 1'b1;
      @(posedge clk);
      @(negedge clk);
      rReady = 1'b0;
    end
    chk(arReady, "R1 ready after held burst", 128'(arReady), 128'd1);

    // R9 reset in mid-burst
    @(negedge clk);
    arValid = 1'b1; arId = 4'h2; arAddr = 32'h200; arLen = 8'd7;
    @(posedge clk);
    @(negedge clk);
    arValid = 1'b0;
    while (!rValid) @(negedge clk);
    rstN = 1'b0;
    @(posedge clk);
    @(negedge clk);
    chk(arReady && !rValid && !memRdEn, "R9 mid-burst reset", {arReady, rValid, memRdEn}, 3'b100);
    rstN = 1'b1;
    @(negedge clk);
    chk(arReady && !rValid, "R9 idle after mid-burst reset", {arReady, rValid}, 2'b10);

    runBurst(4'hC, 32'h0000_0010, 8'd1, 2);

    done = 1'b1;
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", nChecks, nFail);
    $finish;
  end

endmodule